// File: doc/BRIEF.md
# Clock Watchdog with Safe-Frequency Fallback

This block guards the frequency selection of a programmable clock generator. While it is enabled it counts down in coarse time units. Each unit is a fixed number of system clocks, set by a parameter; with the default it is 290 ms at 100 MHz. Software restarts the countdown either with a kick strobe or by writing the timeout count. If the countdown runs out first, the block latches an alarm. It then drives a frequency-select code that software stored in advance, in place of the normal selection.

The normal selection comes from one of two sources: the hardware strap inputs, or a software-programmed select input. A mode bit in the control byte picks between them. The watchdog enable also starts out taken from a strap. The first write to the control byte hands the enable over to a register bit, and the strap is ignored from then on. The alarm stays set until the watchdog is disabled or the block is reset. Disabling clears the alarm and restores the normal source.

The block has two readback ports, one for the timeout count and one for the control byte. The serial bus that carries the register accesses is not part of this block, and neither is the oscillator.

Top module: `clkSafeWatchdog`

## Requirements
- R1: After reset, rdCount reads 8 and rdCtrl reads 0x00. alarm is 0, and freqSel equals strapFreqSel.
- R2: With a timeout count N of at least 1, alarm rises exactly N*TICK_DIV clock edges after the edge that started the countdown. A countdown starts on an enabling control write, a kick or a count write.
- R3: While alarm is 1, freqSel equals the safe code, which is control byte bits 4:0. rdCtrl bit 5 reads 1.
- R4: With no alarm, freqSel follows progFreqSel when control bit 7 is 1 and strapFreqSel when control bit 7 is 0.
- R5: Before the first control write, the watchdog is enabled when strapWdEn is 1. After any control write, control bit 6 alone enables it (1 = enabled), whatever strapWdEn is.
- R6: A kick pulse, or a write to the count register, restarts the countdown from the count register. A count write restarts it from the newly written value. The partial time unit is discarded.
- R7: While alarm is 1, kicks and count writes do not clear the alarm, and freqSel keeps the safe code.
- R8: Disabling the watchdog clears alarm by the second clock edge after the disabling write, and freqSel returns to the normal source.
- R9: A timeout count of 0 raises alarm TICK_DIV edges after the countdown starts, which is the first time-unit tick.
- R10: The value written to control bit 5 is ignored. Writing 1 there neither sets alarm nor reads back as 1.
- R11: rdCount returns the last value written to the count register. This includes a value written while the alarm is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrCount | input | 1 | Write strobe for the timeout count register |
| wrCtrl | input | 1 | Write strobe for the control byte |
| wrData | input | 8 | Write data for both registers |
| kick | input | 1 | Restart pulse for the countdown |
| strapWdEn | input | 1 | Hardware-latched watchdog enable |
| strapFreqSel | input | 5 | Hardware-latched frequency-select code |
| progFreqSel | input | 5 | Software-programmed frequency-select code |
| freqSel | output | 5 | Effective frequency-select code |
| alarm | output | 1 | Watchdog alarm status |
| rdCount | output | 8 | Readback of the timeout count register |
| rdCtrl | output | 8 | Readback of the control byte: mode bit 7, enable bit 6, alarm bit 5, safe code bits 4:0 |

## Verification
A table of four entries runs the timeout path. The entries use different counts, safe codes, source modes and programmed selects, so that a wrong multiple of the tick period shows up, and so does a swapped source or a safe code taken from the wrong bits. Directed runs then cover the remaining behaviour:
- a kick late in the countdown, and a count write in mid-countdown, which tell a real restart from a countdown that merely carries on;
- kicks and count writes during an alarm, and a disable followed by a re-enable;
- a count of 0, and a write of 1 to the alarm bit;
- a reset with the enable strap high, followed by the register taking over the enable in both directions.

// File: rtl/clkSafeWatchdogPkg.sv
package clkSafeWatchdogPkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 5;

  // control byte field positions
  localparam int MODE_BIT  = 7;
  localparam int EN_BIT    = 6;
  localparam int ALARM_BIT = 5;

  typedef struct packed {
    logic run;        // countdown is live (enabled, no alarm)
    logic reload;     // restart countdown
    logic decrement;  // consume one time unit
    logic timeout;    // countdown exhausted this tick
  } wdtStrobe_t;
endpackage

// File: rtl/wdtCtrl.sv
module wdtCtrl
  import clkSafeWatchdogPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       effEn,
  input  logic       preWrap,
  input  logic       remainLe1,
  input  logic       kick,
  input  logic       wrCount,
  output wdtStrobe_t strb,
  output logic       alarm
);
  logic alarmQ;
  logic tick;

  always_comb begin
    strb.run       = effEn && !alarmQ;
    tick           = strb.run && preWrap;
    strb.reload    = strb.run && (kick || wrCount);
    strb.timeout   = tick && remainLe1 && !strb.reload;
    strb.decrement = tick && !remainLe1 && !strb.reload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              alarmQ <= 1'b0;
    else if (!effEn)        alarmQ <= 1'b0;
    else if (strb.timeout)  alarmQ <= 1'b1;
  end

  assign alarm = alarmQ;

  // R2: the alarm only rises on a time-unit tick
  p_alarm_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmQ) |-> $past(preWrap) && $past(effEn));

  // R8: a disabled watchdog holds no alarm one edge later
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    !effEn |=> !alarmQ);

  // R7: an enabled alarm is sticky
  p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (alarmQ && effEn) |=> alarmQ);
endmodule

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import clkSafeWatchdogPkg::*;
#(
  parameter int TICK_DIV  = 29_000_000,
  parameter int COUNT_RST = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobe_t        strb,
  input  logic              alarmIn,
  input  logic              wrCount,
  input  logic              wrCtrl,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              strapWdEn,
  input  logic [CODE_W-1:0] strapFreqSel,
  input  logic [CODE_W-1:0] progFreqSel,
  output logic              effEn,
  output logic              preWrap,
  output logic              remainLe1,
  output logic [CODE_W-1:0] freqSel,
  output logic [BYTE_W-1:0] rdCount,
  output logic [BYTE_W-1:0] rdCtrl
);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [BYTE_W-1:0] countReg;
  logic [BYTE_W-1:0] remain;
  logic [PRE_W-1:0]  pre;
  logic [CODE_W-1:0] safeCode;
  logic              modeBit;
  logic              enBit;
  logic              ovrd;
  logic [CODE_W-1:0] normalSel;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= BYTE_W'(COUNT_RST);
      safeCode <= '0;
      modeBit  <= 1'b0;
      enBit    <= 1'b0;
      ovrd     <= 1'b0;
    end else begin
      if (wrCount) countReg <= wrData;
      if (wrCtrl) begin
        modeBit  <= wrData[MODE_BIT];
        enBit    <= wrData[EN_BIT];
        safeCode <= wrData[CODE_W-1:0];
        ovrd     <= 1'b1;
      end
    end
  end

  assign effEn = ovrd ? enBit : strapWdEn;

  // time-unit prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        pre <= '0;
    else if (!strb.run || strb.reload) pre <= '0;
    else if (pre == PRE_LAST)          pre <= '0;
    else                               pre <= pre + 1'b1;
  end

  assign preWrap = (pre == PRE_LAST);

  // countdown of time units
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               remain <= BYTE_W'(COUNT_RST);
    else if (!effEn)         remain <= countReg;
    else if (strb.reload)    remain <= wrCount ? wrData : countReg;
    else if (strb.decrement) remain <= remain - 1'b1;
  end

  assign remainLe1 = (remain <= BYTE_W'(1));

  // frequency source selection
  assign normalSel = modeBit ? progFreqSel : strapFreqSel;
  assign freqSel   = alarmIn ? safeCode : normalSel;

  assign rdCount = countReg;
  assign rdCtrl  = {modeBit, enBit, alarmIn, safeCode};

  // R2: prescaler never exceeds its period
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    pre <= PRE_LAST);

  // R7: countdown frozen while the alarm persists
  p_remain_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIn && $past(alarmIn) && effEn) |-> remain == $past(remain));

  // R11: count write lands in the register
  p_count_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> countReg == $past(wrData));

  // R10: alarm bit of readback never follows a control write
  p_alarm_not_written_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !alarmIn && !strb.timeout) |=> !rdCtrl[ALARM_BIT]);
endmodule

// File: rtl/clkSafeWatchdog.sv
module clkSafeWatchdog
  import clkSafeWatchdogPkg::*;
#(
  parameter int TICK_DIV  = 29_000_000,
  parameter int COUNT_RST = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCount,
  input  logic              wrCtrl,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              kick,
  input  logic              strapWdEn,
  input  logic [CODE_W-1:0] strapFreqSel,
  input  logic [CODE_W-1:0] progFreqSel,
  output logic [CODE_W-1:0] freqSel,
  output logic              alarm,
  output logic [BYTE_W-1:0] rdCount,
  output logic [BYTE_W-1:0] rdCtrl
);
  wdtStrobe_t strb;
  logic       effEn;
  logic       preWrap;
  logic       remainLe1;

  wdtCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .effEn     (effEn),
    .preWrap   (preWrap),
    .remainLe1 (remainLe1),
    .kick      (kick),
    .wrCount   (wrCount),
    .strb      (strb),
    .alarm     (alarm)
  );

  wdtDatapath #(
    .TICK_DIV  (TICK_DIV),
    .COUNT_RST (COUNT_RST)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .alarmIn      (alarm),
    .wrCount      (wrCount),
    .wrCtrl       (wrCtrl),
    .wrData       (wrData),
    .strapWdEn    (strapWdEn),
    .strapFreqSel (strapFreqSel),
    .progFreqSel  (progFreqSel),
    .effEn        (effEn),
    .preWrap      (preWrap),
    .remainLe1    (remainLe1),
    .freqSel      (freqSel),
    .rdCount      (rdCount),
    .rdCtrl       (rdCtrl)
  );

  // R3: a fresh alarm applies the stored safe code
  p_safe_on_alarm_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarm) |-> freqSel == rdCtrl[CODE_W-1:0]);
endmodule

// File: tb/test_clkSafeWatchdog.sv
module test_clkSafeWatchdog;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrCount = 1'b0;
  logic       wrCtrl = 1'b0;
  logic [7:0] wrData = '0;
  logic       kick = 1'b0;
  logic       strapWdEn = 1'b0;
  logic [4:0] strapFreqSel = 5'h11;
  logic [4:0] progFreqSel = 5'h06;
  logic [4:0] freqSel;
  logic       alarm;
  logic [7:0] rdCount;
  logic [7:0] rdCtrl;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  clkSafeWatchdog #(.TICK_DIV(D), .COUNT_RST(8)) i_clkSafeWatchdog (
    .clk(clk), .rstN(rstN), .wrCount(wrCount), .wrCtrl(wrCtrl),
    .wrData(wrData), .kick(kick), .strapWdEn(strapWdEn),
    .strapFreqSel(strapFreqSel), .progFreqSel(progFreqSel),
    .freqSel(freqSel), .alarm(alarm), .rdCount(rdCount), .rdCtrl(rdCtrl)
  );

  // table: {count, safe code, mode bit, programmed select}
  localparam logic [18:0] VEC [4] = '{
    {8'd1, 5'h15, 1'b0, 5'h03},
    {8'd2, 5'h0C, 1'b1, 5'h1E},
    {8'd3, 5'h1F, 1'b1, 5'h01},
    {8'd5, 5'h02, 1'b0, 5'h09}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCnt(input logic [7:0] v);
    wrCount = 1'b1; wrData = v;
    @(negedge clk);
    wrCount = 1'b0;
  endtask

  task automatic wrCtl(input logic [7:0] v);
    wrCtrl = 1'b1; wrData = v;
    @(negedge clk);
    wrCtrl = 1'b0;
  endtask

  task automatic doKick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 rdCount", rdCount, 8);
    chk("R1 rdCtrl", rdCtrl, 0);
    chk("R1 alarm", alarm, 0);
    chk("R1 freqSel", freqSel, strapFreqSel);

    // table walk: R2 timing, R3 safe code, R8 disable
    foreach (VEC[i]) begin
      logic [7:0] n;
      logic [4:0] safe;
      logic       mode;
      logic [4:0] normal;
      {n, safe, mode, progFreqSel} = VEC[i];
      normal = mode ? progFreqSel : strapFreqSel;
      wrCnt(n);
      wrCtl({mode, 1'b1, 1'b0, safe});
      step(int'(n) * D - 1);
      chk("R2 no alarm before timeout", alarm, 0);
      chk("R4 normal select", freqSel, normal);
      step(1);
      chk("R2 alarm at timeout", alarm, 1);
      chk("R3 safe code applied", freqSel, safe);
      chk("R3 alarm readback bit", rdCtrl[5], 1);
      wrCtl({mode, 1'b0, 1'b0, safe});
      step(2);
      chk("R8 alarm cleared", alarm, 0);
      chk("R8 normal restored", freqSel, normal);
    end

    // R6 kick restarts countdown
    wrCnt(8'd3);
    wrCtl(8'h4A);
    step(10);
    doKick();
    step(11);
    chk("R6 kick delays alarm", alarm, 0);
    step(1);
    chk("R6 alarm after kick restart", alarm, 1);

    // R7 kick and count write ignored during alarm
    doKick();
    step(2);
    chk("R7 alarm holds after kick", alarm, 1);
    chk("R7 safe code holds", freqSel, 5'h0A);
    wrCnt(8'd9);
    step(2);
    chk("R7 alarm holds after count write", alarm, 1);
    chk("R11 count stored during alarm", rdCount, 9);

    // R8 disable then re-enable reloads full count
    wrCtl(8'h0A);
    step(2);
    chk("R8 disable clears alarm", alarm, 0);
    chk("R8 strap source back", freqSel, strapFreqSel);
    wrCtl(8'h4A);
    step(9 * D - 1);
    chk("R8 re-enable full count", alarm, 0);
    step(1);
    chk("R8 re-enable timeout", alarm, 1);

    // R6 count write restarts with new value
    wrCtl(8'h0A);
    wrCnt(8'd3);
    wrCtl(8'h4A);
    step(5);
    wrCnt(8'd2);
    step(2 * D - 1);
    chk("R6 count write restart", alarm, 0);
    step(1);
    chk("R6 count write timeout", alarm, 1);

    // R9 count of zero
    wrCtl(8'h0A);
    wrCnt(8'd0);
    wrCtl(8'h4A);
    step(D - 1);
    chk("R9 zero count before tick", alarm, 0);
    step(1);
    chk("R9 zero count first tick", alarm, 1);

    // R10 alarm bit write ignored
    wrCtl(8'h20);
    step(2);
    chk("R10 disabled write bit5 alarm", alarm, 0);
    chk("R10 readback bit5", rdCtrl[5], 0);
    wrCnt(8'd4);
    wrCtl(8'h60);
    chk("R10 enabled write bit5", alarm, 0);
    chk("R10 enabled readback bit5", rdCtrl[5], 0);

    // R4 source selection with watchdog off
    wrCtl(8'h80);
    progFreqSel = 5'h13;
    step(1);
    chk("R4 programmed source", freqSel, 5'h13);
    wrCtl(8'h00);
    strapFreqSel = 5'h07;
    step(1);
    chk("R4 strap source", freqSel, 5'h07);

    // R5 strap enable before override
    rstN = 1'b0;
    strapWdEn = 1'b1;
    step(2);
    rstN = 1'b1;
    step(8 * D - 1);
    chk("R5 strap enables, before timeout", alarm, 0);
    step(1);
    chk("R5 strap enables, timeout", alarm, 1);
    chk("R5 reset safe code", freqSel, 0);
    wrCtl(8'h00);
    step(2);
    chk("R5 register disables over strap", alarm, 0);
    step(10 * D);
    chk("R5 stays disabled", alarm, 0);
    strapWdEn = 1'b0;
    wrCtl(8'h40);
    step(8 * D - 1);
    chk("R5 register enables, before timeout", alarm, 0);
    step(1);
    chk("R5 register enables over strap", alarm, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule